// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one 32-bit timer channel. A free-running prescaler produces a count-enable pulse at one of five fixed fractions of the system clock, or follows an external tick input. While the run input is high, each enable pulse decrements the count register. When the count is zero at an enable pulse, the count is reloaded from the reload register and a sticky underflow flag is set. An interrupt output is the flag gated by an enable bit in the control register.

Software reaches four word registers through a simple write-strobe bus with a combinational read path. The word index selects reload (0), count (1), control (2) or capture (3), that is byte offsets 0x0, 0x4, 0x8 and 0xC. The capture word is not implemented as storage and always reads a fixed parameter value.

Top module: `tmr_channel`

## Requirements
- R1: After reset the reload and count words read 0xFFFFFFFF, the control word reads 0 and irq_o is low.
- R2: Control bits [2:0] pick the decrement period while run_i is high: code 0 gives one decrement every 4 clocks, 1 every 16, 2 every 64, 3 every 256, 4 every 1024.
- R3: irq_o is high exactly when the underflow flag (control bit 8) is set and the interrupt enable (control bit 5) is 1.
- R4: A control write with bit 8 equal to 0 clears the underflow flag; with bit 8 equal to 1 the flag keeps its value.
- R5: A decrement step with the count at zero loads the count from the reload word and sets the underflow flag.
- R6: Codes 5 and 6 never produce a step; code 7 steps once per clock in which ext_tick_i is high when the EXT_CLK_EN parameter is 1, and never otherwise.
- R7: With run_i low the count holds its value; when run_i returns high counting resumes from the held value.
- R8: A control read returns the written bits [7:0], the live underflow flag in bit 8, and zero in bit 9 and bits [31:10].
- R9: Writes to the reload and count words take effect at the write clock edge and are visible on the next read; a count write overrides a step in the same cycle.
- R10: The capture word reads CAPT_VALUE and writes to it change nothing.
- R11: No decrement step happens in any cycle in which the control word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High to let the channel count |
| ext_tick_i | input | 1 | External count pulse, used with rate code 7 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word index: 0 reload, 1 count, 2 control, 3 capture |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Underflow interrupt |

## Verification
Register writes land at the clock edge that samples wr_en_i, and reads are combinational, so the bench drives on the falling edge and reads back at the next falling edge, one cycle after the write. The underflow flag and irq_o change at the same edge as the reload, so the bench polls the count once per cycle and checks flag and interrupt in the cycle it first sees the reload value. Prescale periods are measured as the number of cycles between two consecutive count changes, which is independent of the prescaler phase, and the first change after a control write is skipped because that write pauses the step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned CTRL_KEEP_W = 8;
  localparam int unsigned IRQ_EN_BIT = 5;
  localparam int unsigned FLAG_BIT   = 8;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned NUM_RATES  = 5,
  parameter int unsigned BASE_SHIFT = 2,
  parameter int unsigned STEP_SHIFT = 2,
  parameter bit          EXT_EN     = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [tmr_pkg::SEL_W-1:0] sel_i,
  input  logic                   ext_tick_i,
  output logic                   tick_o
);
  localparam int unsigned PRE_W = BASE_SHIFT + STEP_SHIFT * (NUM_RATES - 1);
  localparam logic [tmr_pkg::SEL_W-1:0] NUM_SEL  = tmr_pkg::SEL_W'(NUM_RATES);
  localparam logic [tmr_pkg::SEL_W-1:0] EXT_CODE = '1;

  logic [PRE_W-1:0]     pre_q;
  logic [PRE_W-1:0]     pre_d;
  logic [NUM_RATES-1:0] rate_hit;

  always_comb pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int unsigned HW = BASE_SHIFT + STEP_SHIFT * g;
    assign rate_hit[g] = &pre_q[HW-1:0];
  end

  always_comb begin
    tick_o = 1'b0;
    if (sel_i < NUM_SEL)
      tick_o = rate_hit[sel_i];
    else if (EXT_EN && (sel_i == EXT_CODE))
      tick_o = ext_tick_i;
  end
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int unsigned W = tmr_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         hold_i,
  input  logic         reload_wr_i,
  input  logic         count_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         step_o,
  output logic [W-1:0] reload_o,
  output logic [W-1:0] count_o,
  output logic         unf_o
);
  logic [W-1:0] reload_q, reload_d;
  logic [W-1:0] count_q, count_d;
  logic         at_zero;

  always_comb begin
    at_zero  = (count_q == '0);
    step_o   = run_i & tick_i & ~hold_i;
    unf_o    = step_o & at_zero & ~count_wr_i;
    reload_d = reload_wr_i ? wdata_i : reload_q;
    count_d  = count_q;
    if (count_wr_i)
      count_d = wdata_i;
    else if (step_o)
      count_d = at_zero ? reload_q : count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      count_q  <= '1;
    end else begin
      reload_q <= reload_d;
      count_q  <= count_d;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_i,
  input  logic [tmr_pkg::FLAG_BIT:0]          wdata_i,
  input  logic                               unf_set_i,
  output logic [tmr_pkg::CTRL_KEEP_W-1:0]     ctrl_o,
  output logic                               flag_o
);
  logic [tmr_pkg::CTRL_KEEP_W-1:0] ctrl_q, ctrl_d;
  logic                            flag_q, flag_d;

  always_comb begin
    ctrl_d = wr_i ? wdata_i[tmr_pkg::CTRL_KEEP_W-1:0] : ctrl_q;
    flag_d = flag_q;
    if (unf_set_i)
      flag_d = 1'b1;
    else if (wr_i && !wdata_i[tmr_pkg::FLAG_BIT])
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned NUM_RATES  = 5,
  parameter bit          EXT_CLK_EN = 1'b1,
  parameter logic [31:0] CAPT_VALUE = 32'h5A5A_0F0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_i,
  input  logic        ext_tick_i,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  import tmr_pkg::*;

  reg_sel_e                sel;
  logic                    reload_wr, count_wr, ctrl_wr;
  logic                    tick, step, unf;
  logic [DATA_W-1:0]       reload_val, count_val;
  logic [CTRL_KEEP_W-1:0]  ctrl_val;
  logic                    flag;

  always_comb begin
    sel       = reg_sel_e'(addr_i);
    reload_wr = wr_en_i && (sel == REG_RELOAD);
    count_wr  = wr_en_i && (sel == REG_COUNT);
    ctrl_wr   = wr_en_i && (sel == REG_CTRL);
  end

  tmr_prescaler #(
    .NUM_RATES (NUM_RATES),
    .BASE_SHIFT(2),
    .STEP_SHIFT(2),
    .EXT_EN    (EXT_CLK_EN)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (ctrl_val[SEL_W-1:0]),
    .ext_tick_i(ext_tick_i),
    .tick_o    (tick)
  );

  tmr_count_unit #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .run_i      (run_i),
    .hold_i     (ctrl_wr),
    .reload_wr_i(reload_wr),
    .count_wr_i (count_wr),
    .wdata_i    (wdata_i),
    .step_o     (step),
    .reload_o   (reload_val),
    .count_o    (count_val),
    .unf_o      (unf)
  );

  tmr_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (ctrl_wr),
    .wdata_i  (wdata_i[FLAG_BIT:0]),
    .unf_set_i(unf),
    .ctrl_o   (ctrl_val),
    .flag_o   (flag)
  );

  always_comb begin
    unique case (sel)
      REG_RELOAD: rdata_o = reload_val;
      REG_COUNT:  rdata_o = count_val;
      REG_CTRL:   rdata_o = {{(DATA_W-FLAG_BIT-1){1'b0}}, flag, ctrl_val};
      default:    rdata_o = CAPT_VALUE;
    endcase
  end

  assign irq_o = flag & ctrl_val[IRQ_EN_BIT];
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_i,
  input logic        ctrl_wr,
  input logic        count_wr,
  input logic        flag_wbit,
  input logic        step,
  input logic [31:0] count_q,
  input logic [31:0] reload_q,
  input logic        flag,
  input logic        irq_o
);
  AST_STEP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !count_wr && count_q != 32'd0) |=> count_q == $past(count_q) - 32'd1); // R2

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag); // R3

  AST_FLAG_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && flag_wbit) |=> flag == $past(flag)); // R4

  AST_ZERO_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !count_wr && count_q == 32'd0) |=> (count_q == $past(reload_q)) && flag); // R5

  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(step && count_q == 32'd0)); // R5

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !count_wr) |=> $stable(count_q)); // R7

  AST_CTRL_WRITE_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> $stable(count_q)); // R11
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_i    (run_i),
  .ctrl_wr  (ctrl_wr),
  .count_wr (count_wr),
  .flag_wbit(wdata_i[8]),
  .step     (step),
  .count_q  (count_val),
  .reload_q (reload_val),
  .flag     (flag),
  .irq_o    (irq_o)
);

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  localparam logic [31:0] CAPT = 32'h5A5A_0F0F;
  localparam logic [1:0] A_RLD = 2'd0, A_CNT = 2'd1, A_CTL = 2'd2, A_CAP = 2'd3;

  logic        clk;
  logic        rst_n;
  logic        run_i;
  logic        ext_tick_i;
  logic        wr_en_i;
  logic [1:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk;
  int n_bad;

  tmr_channel #(.NUM_RATES(5), .EXT_CLK_EN(1'b1), .CAPT_VALUE(CAPT)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ext_tick_i(ext_tick_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  // Poll count every cycle until it differs from old; returns new value and cycles waited.
  task automatic wait_change(input logic [31:0] old, input int limit,
                             output logic [31:0] nv, output int cyc);
    cyc = 0;
    nv  = old;
    while (nv == old && cyc < limit) begin
      @(negedge clk);
      cyc++;
      reg_rd(A_CNT, nv);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(A_RLD, d); chk("R1 reload reset", d, 32'hFFFF_FFFF);
    reg_rd(A_CNT, d); chk("R1 count reset", d, 32'hFFFF_FFFF);
    reg_rd(A_CTL, d); chk("R1 ctrl reset", d, 32'h0);
    chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_rate(input logic [2:0] code, input int period);
    logic [31:0] a, b, c;
    int cy;
    run_i = 1'b0;
    reg_wr(A_CTL, {29'b0, code});
    reg_wr(A_CNT, 32'h1000_0000);
    run_i = 1'b1;
    reg_rd(A_CNT, a);
    wait_change(a, period + 8, b, cy);
    wait_change(b, period + 8, c, cy);
    chk($sformatf("R2 period code %0d", code), cy, period);
    chk($sformatf("R2 step size code %0d", code), b - c, 32'd1);
    run_i = 1'b0;
  endtask

  task automatic t_underflow();
    logic [31:0] d, nv;
    int cy;
    run_i = 1'b0;
    reg_wr(A_CTL, 32'h0);
    reg_wr(A_RLD, 32'd5);
    reg_wr(A_CNT, 32'd1);
    run_i = 1'b1;
    wait_change(32'd1, 40, nv, cy);
    chk("R2 one to zero", nv, 32'd0);
    wait_change(32'd0, 40, nv, cy);
    run_i = 1'b0;
    chk("R5 reload value", nv, 32'd5);
    reg_rd(A_CTL, d);
    chk("R5 flag set", d, 32'h100);
    chk("R3 irq off when disabled", {31'b0, irq_o}, 32'h0);
    reg_wr(A_CTL, 32'h120);
    reg_rd(A_CTL, d);
    chk("R4 write one keeps flag", d, 32'h120);
    chk("R3 irq with flag and enable", {31'b0, irq_o}, 32'h1);
    reg_wr(A_CTL, 32'h020);
    reg_rd(A_CTL, d);
    chk("R4 write zero clears flag", d, 32'h020);
    chk("R3 irq drops with flag", {31'b0, irq_o}, 32'h0);
    reg_wr(A_CTL, 32'h120);
    reg_rd(A_CTL, d);
    chk("R4 write one does not set", d, 32'h020);
  endtask

  task automatic t_stop();
    logic [31:0] a, b, nv;
    int cy;
    run_i = 1'b0;
    reg_wr(A_CTL, 32'h0);
    reg_wr(A_CNT, 32'd700);
    repeat (100) @(negedge clk);
    reg_rd(A_CNT, a);
    chk("R7 held while stopped", a, 32'd700);
    run_i = 1'b1;
    wait_change(a, 20, nv, cy);
    run_i = 1'b0;
    chk("R7 resumes from held", nv, 32'd699);
    repeat (30) @(negedge clk);
    reg_rd(A_CNT, b);
    chk("R7 held again", b, 32'd699);
  endtask

  task automatic t_codes();
    logic [31:0] d;
    for (int k = 5; k <= 6; k++) begin
      run_i = 1'b0;
      reg_wr(A_CTL, 32'(k));
      reg_wr(A_CNT, 32'd50);
      run_i = 1'b1;
      repeat (2100) @(negedge clk);
      run_i = 1'b0;
      reg_rd(A_CNT, d);
      chk($sformatf("R6 code %0d halts", k), d, 32'd50);
    end
    reg_wr(A_CTL, 32'h7);
    reg_wr(A_CNT, 32'd50);
    run_i = 1'b1;
    repeat (20) @(negedge clk);
    reg_rd(A_CNT, d);
    chk("R6 code 7 no ext pulses", d, 32'd50);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); ext_tick_i = 1'b1;
      @(negedge clk); ext_tick_i = 1'b0;
    end
    reg_rd(A_CNT, d);
    chk("R6 code 7 three ext pulses", d, 32'd47);
    run_i = 1'b0;
  endtask

  task automatic t_ctrl_read();
    logic [31:0] d;
    reg_wr(A_CTL, 32'hFFFF_FEFF);
    reg_rd(A_CTL, d);
    chk("R8 reserved bits read zero", d, 32'h0000_00FF);
    reg_wr(A_CTL, 32'h0000_02A5);
    reg_rd(A_CTL, d);
    chk("R8 stored low bits", d, 32'h0000_00A5);
  endtask

  task automatic t_writes();
    logic [31:0] d;
    reg_wr(A_CTL, 32'h0);
    run_i = 1'b1;
    reg_wr(A_CNT, 32'hCAFE_0000);
    reg_rd(A_CNT, d);
    chk("R9 count write immediate", d, 32'hCAFE_0000);
    reg_wr(A_RLD, 32'h1234_5678);
    reg_rd(A_RLD, d);
    chk("R9 reload write", d, 32'h1234_5678);
    run_i = 1'b0;
    reg_rd(A_CAP, d);
    chk("R10 capture fixed", d, CAPT);
    reg_wr(A_CAP, 32'h0);
    reg_rd(A_CAP, d);
    chk("R10 capture write ignored", d, CAPT);
    reg_rd(A_RLD, d);
    chk("R10 capture write no side effect", d, 32'h1234_5678);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    run_i = 1'b0;
    reg_wr(A_CNT, 32'd900);
    run_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = A_CTL; wdata_i = 32'h0;
    repeat (40) @(negedge clk);
    wr_en_i = 1'b0;
    reg_rd(A_CNT, d);
    chk("R11 no step during control writes", d, 32'd900);
    run_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; run_i = 1'b0; ext_tick_i = 1'b0;
    wr_en_i = 1'b0; addr_i = 2'd0; wdata_i = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate(3'd0, 4);
    t_rate(3'd1, 16);
    t_rate(3'd2, 64);
    t_rate(3'd3, 256);
    t_rate(3'd4, 1024);
    t_underflow();
    t_stop();
    t_codes();
    t_ctrl_read();
    t_writes();
    t_pause();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule